// File: doc/BRIEF.md
# Codec Outbound Frame Assembler

This block is the codec end of an AC'97-style serial link. It builds each outgoing frame and shifts it out one bit per bit clock, most significant bit first. Each frame starts one bit clock after the controller raises the frame sync. A frame carries a 16-bit tag slot and then 20-bit data slots. This block fills the tag slot and the first three data slots. Every later bit position in the frame is driven low.

Register commands are decoded from the inbound frame by a separate decoder and reach this block as single-cycle strobes. A read command is answered in the next outgoing frame. That frame echoes the 7-bit register index and returns the 16-bit register value, which this block fetches through a combinational register-file read port. The register file also supplies a mask of defined bits. Undefined bit positions keep the value they had in the previous read-back, so the bus appears to hold its last state. An 18-bit left-channel capture sample is latched on its strobe and placed left-justified in the third data slot of the next frame.

Top module: `codec_frame_tx`

## Requirements
- R1: After reset, and until the first frame sync is sampled high, `sdata` is 0.
- R2: Frame bit time 0 appears on `sdata` in the cycle after the rising edge that samples `sync` high, and one bit follows per clock. Tag bit 15 is sent at bit time 0 and is always 1.
- R3: Every slot is sent MSB first. Tag bits 15..0 occupy bit times 0..15, slot 1 occupies 16..35, slot 2 occupies 36..55 and slot 3 occupies 56..75. Slot bit 19 goes out first in each slot.
- R4: A read command strobed during a frame is answered in the frame started by the next sync. Slot 1 bits 18..12 carry the index, and slot 1 bit 19 and bits 11..0 are 0. Tag bits 14 and 13 are both 1 in that frame.
- R5: In a frame that answers a read, slot 2 bits 19..4 carry the 16-bit read-back value and slot 2 bits 3..0 are 0.
- R6: A write command produces no echo: slots 1 and 2 are all zero and tag bits 14 and 13 are 0. When several commands arrive before one sync, only the last one counts.
- R7: For each read-back bit whose defined-mask bit is 0, the returned value equals the same bit of the previous read-back value (0 after reset). Bits whose mask bit is 1 return the register data.
- R8: When a capture strobe arrived since the last sync, slot 3 bits 19..2 carry the 18-bit sample, bits 1..0 are 0 and tag bit 12 is 1. Otherwise slot 3 is all zero and tag bit 12 is 0.
- R9: Tag bits 11..0 and all bit times from 76 to the end of the frame are 0.
- R10: A read is answered once only. A frame with no new read command before its sync carries zero slots 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; `sdata` changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync; the next frame starts the cycle after it is sampled high |
| cmd_valid | input | 1 | Single-cycle strobe of a decoded register command |
| cmd_is_read | input | 1 | 1 = read command, 0 = write command |
| cmd_index | input | 7 | Register index of the command |
| rf_index | output | 7 | Register-file read address (index of the pending read) |
| rf_rdata | input | 16 | Register-file read data for `rf_index`, combinational |
| rf_defmask | input | 16 | 1 for each defined bit of the register at `rf_index` |
| cap_strobe | input | 1 | Single-cycle strobe of a new capture sample |
| cap_sample | input | 18 | Two's complement left capture sample |
| sdata | output | 1 | Serial frame output, MSB first |

## Verification
A lost or stale pending-read flag shows as tag bits 14 and 13 and slot 1 being wrong at bit times 1, 2 and 16..35 of the first frame after the command. So it is visible within one frame period plus 36 clocks. A corrupted hold register for undefined bits stays hidden until a read of a register with a partial mask. It then shows in slot 2 at bit times 36..51 of the answering frame. A shift-register or slot-placement fault moves or smears bits. The per-clock compare reports it at the first wrong bit time, which may lie in the zero tail after bit time 75.

// File: rtl/codec_frame_pkg.sv
package codec_frame_pkg;

   localparam int TAG_BITS_DEF   = 16;
   localparam int SLOT_BITS_DEF  = 20;
   localparam int INDEX_BITS_DEF = 7;
   localparam int REG_BITS_DEF   = 16;
   localparam int CAP_BITS_DEF   = 18;
   localparam int FRAME_LEN_DEF  = 256;

   // Flags carried in the top four tag bits, frame-valid first
   typedef struct packed {
      logic frame_ok;
      logic addr_ok;
      logic data_ok;
      logic cap_ok;
   } tag_flags_t;

   localparam int TAG_FLAG_BITS = $bits(tag_flags_t);

endpackage

// File: rtl/codec_rd_return.sv
module codec_rd_return #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 16,
   parameter int SLOT_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              cmd_valid,
   input  logic              cmd_is_read,
   input  logic [IDX_W-1:0]  cmd_index,
   output logic [IDX_W-1:0]  rf_index,
   input  logic [DATA_W-1:0] rf_rdata,
   input  logic [DATA_W-1:0] rf_defmask,
   output logic [SLOT_W-1:0] addr_slot,
   output logic [SLOT_W-1:0] data_slot,
   output logic              rd_ok
);

   localparam int ADDR_PAD = SLOT_W - 1 - IDX_W;
   localparam int DATA_PAD = SLOT_W - DATA_W;

   logic              pend_v_q;
   logic [IDX_W-1:0]  pend_idx_q;
   logic [DATA_W-1:0] keep_q;
   logic [DATA_W-1:0] merged;
   logic [SLOT_W-1:0] data_word;
   logic              new_read;

   assign new_read = cmd_valid && cmd_is_read;
   assign merged   = (rf_rdata & rf_defmask) | (keep_q & ~rf_defmask);
   assign rf_index = pend_idx_q;
   assign rd_ok    = pend_v_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v_q   <= 1'b0;
         pend_idx_q <= '0;
         keep_q     <= '0;
      end else if (sync) begin
         if (pend_v_q) begin
            keep_q <= merged;
         end
         pend_v_q <= new_read;
         if (new_read) begin
            pend_idx_q <= cmd_index;
         end
      end else if (cmd_valid) begin
         pend_v_q <= cmd_is_read;
         if (cmd_is_read) begin
            pend_idx_q <= cmd_index;
         end
      end
   end

   generate
      if (DATA_PAD == 0) begin : g_data_full
         assign data_word = merged;
      end else begin : g_data_pad
         assign data_word = {merged, {DATA_PAD{1'b0}}};
      end
   endgenerate

   assign addr_slot = pend_v_q ? {1'b0, pend_idx_q, {ADDR_PAD{1'b0}}} : '0;
   assign data_slot = pend_v_q ? data_word : '0;

   // R10
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && !new_read) |=> !pend_v_q);

   // R6
   write_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_is_read) |=> !pend_v_q);

   // R4
   read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_read |=> (pend_v_q && pend_idx_q == $past(cmd_index)));

   // R7
   keep_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && pend_v_q) |=>
         ((keep_q & ~$past(rf_defmask)) == ($past(keep_q) & ~$past(rf_defmask))));

endmodule

// File: rtl/codec_cap_hold.sv
module codec_cap_hold #(
   parameter int CAP_W  = 18,
   parameter int SLOT_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              cap_strobe,
   input  logic [CAP_W-1:0]  cap_sample,
   output logic [SLOT_W-1:0] cap_slot,
   output logic              cap_ok
);

   localparam int CAP_PAD = SLOT_W - CAP_W;

   logic             have_q;
   logic [CAP_W-1:0] samp_q;
   logic [SLOT_W-1:0] just_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_q <= 1'b0;
         samp_q <= '0;
      end else begin
         if (cap_strobe) begin
            have_q <= 1'b1;
            samp_q <= cap_sample;
         end else if (sync) begin
            have_q <= 1'b0;
         end
      end
   end

   generate
      if (CAP_PAD == 0) begin : g_cap_full
         assign just_word = samp_q;
      end else begin : g_cap_left
         assign just_word = {samp_q, {CAP_PAD{1'b0}}};
      end
   endgenerate

   assign cap_slot = have_q ? just_word : '0;
   assign cap_ok   = have_q;

   // R8
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe |=> (have_q && samp_q == $past(cap_sample)));

   // R8
   cap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && !cap_strobe) |=> !have_q);

endmodule

// File: rtl/codec_frame_shift.sv
module codec_frame_shift #(
   parameter int FW = 76
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [FW-1:0] load_vec,
   output logic          sdata
);

   logic [FW-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_vec;
      end else begin
         sh_q <= {sh_q[FW-2:0], 1'b0};
      end
   end

   assign sdata = sh_q[FW-1];

   // R3
   shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (sdata == $past(sh_q[FW-2])));

endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx
   import codec_frame_pkg::*;
#(
   parameter int TAG_W     = TAG_BITS_DEF,
   parameter int SLOT_W    = SLOT_BITS_DEF,
   parameter int IDX_W     = INDEX_BITS_DEF,
   parameter int DATA_W    = REG_BITS_DEF,
   parameter int CAP_W     = CAP_BITS_DEF,
   parameter int FRAME_LEN = FRAME_LEN_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync,
   input  logic              cmd_valid,
   input  logic              cmd_is_read,
   input  logic [IDX_W-1:0]  cmd_index,
   output logic [IDX_W-1:0]  rf_index,
   input  logic [DATA_W-1:0] rf_rdata,
   input  logic [DATA_W-1:0] rf_defmask,
   input  logic              cap_strobe,
   input  logic [CAP_W-1:0]  cap_sample,
   output logic              sdata
);

   localparam int FW    = TAG_W + 3 * SLOT_W;
   localparam int POS_W = $clog2(FRAME_LEN);
   localparam int TPAD  = TAG_W - TAG_FLAG_BITS;

   generate
      if (IDX_W + 1 >= SLOT_W) begin : g_bad_idx
         $error("index does not fit the address slot");
      end
      if (DATA_W > SLOT_W) begin : g_bad_data
         $error("register width exceeds slot width");
      end
      if (CAP_W > SLOT_W) begin : g_bad_cap
         $error("capture width exceeds slot width");
      end
      if (TAG_W <= TAG_FLAG_BITS) begin : g_bad_tag
         $error("tag slot too narrow");
      end
      if (FRAME_LEN < FW) begin : g_bad_len
         $error("frame shorter than the assembled slots");
      end
   endgenerate

   logic [SLOT_W-1:0] addr_slot;
   logic [SLOT_W-1:0] data_slot;
   logic [SLOT_W-1:0] cap_slot;
   logic              rd_ok;
   logic              cap_ok;
   tag_flags_t        flags;
   logic [TAG_W-1:0]  tag_word;
   logic [FW-1:0]     frame_vec;
   logic [POS_W-1:0]  pos_q;
   logic              seen_q;

   codec_rd_return #(
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W),
      .SLOT_W (SLOT_W)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync        (sync),
      .cmd_valid   (cmd_valid),
      .cmd_is_read (cmd_is_read),
      .cmd_index   (cmd_index),
      .rf_index    (rf_index),
      .rf_rdata    (rf_rdata),
      .rf_defmask  (rf_defmask),
      .addr_slot   (addr_slot),
      .data_slot   (data_slot),
      .rd_ok       (rd_ok)
   );

   codec_cap_hold #(
      .CAP_W  (CAP_W),
      .SLOT_W (SLOT_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync       (sync),
      .cap_strobe (cap_strobe),
      .cap_sample (cap_sample),
      .cap_slot   (cap_slot),
      .cap_ok     (cap_ok)
   );

   always_comb begin
      flags.frame_ok = 1'b1;
      flags.addr_ok  = rd_ok;
      flags.data_ok  = rd_ok;
      flags.cap_ok   = cap_ok;
   end

   assign tag_word  = {flags, {TPAD{1'b0}}};
   assign frame_vec = {tag_word, addr_slot, data_slot, cap_slot};

   codec_frame_shift #(
      .FW (FW)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sync),
      .load_vec (frame_vec),
      .sdata    (sdata)
   );

   // Bit-time counter, kept apart from the shifter for checking
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= '0;
         seen_q <= 1'b0;
      end else if (sync) begin
         pos_q  <= '0;
         seen_q <= 1'b1;
      end else if (pos_q != POS_W'(FRAME_LEN - 1)) begin
         pos_q <= pos_q + 1'b1;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !sdata);

   // R2
   frame_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && pos_q == '0) |-> sdata);

   // R9
   tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && pos_q >= POS_W'(FW)) |-> !sdata);

   // R9
   tag_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && pos_q >= POS_W'(TAG_FLAG_BITS) && pos_q < POS_W'(TAG_W)) |-> !sdata);

endmodule

// File: tb/tb_codec_frame_tx.sv
`timescale 1ns/1ps
module tb_codec_frame_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_is_read = 1'b0;
   logic [6:0]  cmd_index = '0;
   logic [6:0]  rf_index;
   logic [15:0] rf_rdata;
   logic [15:0] rf_defmask;
   logic        cap_strobe = 1'b0;
   logic [17:0] cap_sample = '0;
   logic        sdata;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   function automatic logic [15:0] reg_val(input logic [6:0] i);
      return 16'hA5C3 ^ {i, i, 2'b10};
   endfunction

   function automatic logic [15:0] reg_mask(input logic [6:0] i);
      return i[0] ? 16'h0FF0 : 16'hFFFF;
   endfunction

   assign rf_rdata   = reg_val(rf_index);
   assign rf_defmask = reg_mask(rf_index);

   codec_frame_tx dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync        (sync),
      .cmd_valid   (cmd_valid),
      .cmd_is_read (cmd_is_read),
      .cmd_index   (cmd_index),
      .rf_index    (rf_index),
      .rf_rdata    (rf_rdata),
      .rf_defmask  (rf_defmask),
      .cap_strobe  (cap_strobe),
      .cap_sample  (cap_sample),
      .sdata       (sdata)
   );

   // Behavioural reference model, updated on each rising edge
   logic [0:255] m_frame;
   logic [0:255] got;
   bit           m_seen = 0;
   int           m_pos = 0;
   bit           m_pend = 0;
   logic [6:0]   m_idx = '0;
   logic [15:0]  m_keep = '0;
   bit           m_have = 0;
   logic [17:0]  m_cap = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_seen = 0; m_pos = 0; m_pend = 0; m_keep = '0; m_have = 0;
         m_frame = '0;
      end else if (sync) begin
         logic [15:0] rb;
         m_frame = '0;
         m_frame[0] = 1'b1;
         if (m_pend) begin
            m_frame[1] = 1'b1;
            m_frame[2] = 1'b1;
            // R3: slot bit b goes to bit time start + (19 - b)
            for (int b = 12; b <= 18; b++) m_frame[16 + 19 - b] = m_idx[b - 12];
            rb = (reg_val(m_idx) & reg_mask(m_idx)) | (m_keep & ~reg_mask(m_idx));
            m_keep = rb;
            for (int b = 4; b <= 19; b++) m_frame[36 + 19 - b] = rb[b - 4];
         end
         if (m_have) begin
            m_frame[3] = 1'b1;
            for (int b = 2; b <= 19; b++) m_frame[56 + 19 - b] = m_cap[b - 2];
         end
         m_have = cap_strobe;
         if (cap_strobe) m_cap = cap_sample;
         m_pend = cmd_valid && cmd_is_read;
         if (m_pend) m_idx = cmd_index;
         m_seen = 1;
         m_pos  = 0;
      end else begin
         if (cmd_valid) begin
            m_pend = cmd_is_read;
            if (cmd_is_read) m_idx = cmd_index;
         end
         if (cap_strobe) begin
            m_have = 1;
            m_cap  = cap_sample;
         end
         m_pos++;
      end
   end

   function automatic string req_of(input bit seen, input int p);
      if (!seen)   return "R1";
      if (p == 0)  return "R2";
      if (p <= 2)  return "R4";
      if (p == 3)  return "R8";
      if (p < 16)  return "R9";
      if (p < 36)  return "R4";
      if (p < 56)  return "R5/R7";
      if (p < 76)  return "R8";
      return "R9";
   endfunction

   bit started = 0;

   // Per-clock compare, sampled on the falling edge
   always @(negedge clk) begin
      if (started) begin
         logic e;
         e = (m_seen && m_pos < 256) ? m_frame[m_pos] : 1'b0;
         checks++;
         if (sdata !== e) begin
            fails++;
            $display("FAIL %s bit time %0d: sdata=%b expected %b",
                     req_of(m_seen, m_pos), m_pos, sdata, e);
         end
         if (m_seen && m_pos < 256) got[m_pos] = sdata;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] slot_at(input int start);
      logic [19:0] s;
      for (int b = 0; b < 20; b++) s[19 - b] = got[start + b];
      return s;
   endfunction

   function automatic logic [15:0] tag_of();
      logic [15:0] t;
      for (int b = 0; b < 16; b++) t[15 - b] = got[b];
      return t;
   endfunction

   function automatic bit tail_zero();
      for (int p = 76; p < 256; p++) if (got[p] !== 1'b0) return 0;
      return 1;
   endfunction

   // One frame of stimulus; sync is raised in its last cycle
   task automatic frame(input bit c1v, input bit c1r, input logic [6:0] c1i,
                        input bit c2v, input bit c2r, input logic [6:0] c2i,
                        input bit cv, input logic [17:0] cd);
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         cmd_valid  = 1'b0;
         cap_strobe = 1'b0;
         sync       = (i == 255);
         if (i == 40 && c1v) begin
            cmd_valid = 1'b1; cmd_is_read = c1r; cmd_index = c1i;
         end
         if (i == 120 && c2v) begin
            cmd_valid = 1'b1; cmd_is_read = c2r; cmd_index = c2i;
         end
         if (i == 60 && cv) begin
            cap_strobe = 1'b1; cap_sample = cd;
         end
      end
   endtask

   logic [15:0] k12, k13, k7f;

   initial begin
      repeat (4) @(negedge clk);
      started = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle stretch with no sync yet
      repeat (20) @(negedge clk);
      chk(sdata === 1'b0, "R1 idle before sync", {31'b0, sdata}, 32'h0);

      // Frame 0 stimulus: read 0x12, capture sample
      frame(1, 1, 7'h12, 0, 0, 7'h00, 1, 18'h2ABCD);
      // Frame 1 out: answers read 0x12; stimulus: write 0x05
      frame(1, 0, 7'h05, 0, 0, 7'h00, 0, 18'h0);
      k12 = reg_val(7'h12);
      chk(tag_of()[15] === 1'b1, "R2 frame valid tag", {16'b0, tag_of()}, 32'h8000);
      chk(tag_of()[14:13] === 2'b11, "R4 read tag flags", {30'b0, tag_of()[14:13]}, 32'h3);
      chk(slot_at(16) === {1'b0, 7'h12, 12'h000}, "R4 index echo", {12'b0, slot_at(16)}, {12'b0, 1'b0, 7'h12, 12'h000});
      chk(slot_at(36) === {k12, 4'h0}, "R5 read data slot", {12'b0, slot_at(36)}, {12'b0, k12, 4'h0});
      chk(slot_at(56) === {18'h2ABCD, 2'b00}, "R8 capture slot", {12'b0, slot_at(56)}, {12'b0, 18'h2ABCD, 2'b00});
      chk(got[56] === 1'b1 && got[73] === 1'b1 && got[57] === 1'b0, "R3 MSB first in slot 3", {29'b0, got[56], got[57], got[73]}, 32'h5);
      chk(tag_of()[12] === 1'b1, "R8 capture tag", {31'b0, tag_of()[12]}, 32'h1);
      chk(tag_of()[11:0] === 12'h000, "R9 tag low bits", {20'b0, tag_of()[11:0]}, 32'h0);
      chk(tail_zero(), "R9 tail zero", 32'h0, 32'h0);

      // Frame 2 out: write gives no echo; stimulus: read 0x13 (partial mask), negative sample
      frame(1, 1, 7'h13, 0, 0, 7'h00, 1, 18'h3FFFF);
      chk(slot_at(16) === 20'h0 && slot_at(36) === 20'h0, "R6 write slots zero", {12'b0, slot_at(16)}, 32'h0);
      chk(tag_of()[14:13] === 2'b00, "R6 write tag flags", {30'b0, tag_of()[14:13]}, 32'h0);
      chk(tag_of()[12] === 1'b0 && slot_at(56) === 20'h0, "R8 no capture", {12'b0, slot_at(56)}, 32'h0);

      // Frame 3 out: read 0x13 with held undefined bits; stimulus: none
      frame(0, 0, 7'h00, 0, 0, 7'h00, 0, 18'h0);
      k13 = (reg_val(7'h13) & 16'h0FF0) | (k12 & 16'hF00F);
      chk(slot_at(36) === {k13, 4'h0}, "R7 undefined bits held", {12'b0, slot_at(36)}, {12'b0, k13, 4'h0});
      chk(slot_at(56) === {18'h3FFFF, 2'b00}, "R8 negative sample", {12'b0, slot_at(56)}, {12'b0, 18'h3FFFF, 2'b00});

      // Frame 4 out: no new read; stimulus: read 0x7F then write 0x01
      frame(1, 1, 7'h7F, 1, 0, 7'h01, 1, 18'h00001);
      chk(slot_at(16) === 20'h0 && tag_of()[14] === 1'b0, "R10 answered once", {12'b0, slot_at(16)}, 32'h0);

      // Frame 5 out: last command was a write; stimulus: write 0x00 then read 0x7F
      frame(1, 0, 7'h00, 1, 1, 7'h7F, 0, 18'h0);
      chk(slot_at(16) === 20'h0 && tag_of()[13] === 1'b0, "R6 last command wins (write)", {12'b0, slot_at(16)}, 32'h0);
      chk(slot_at(56) === {18'h00001, 2'b00}, "R8 sample LSB placement", {12'b0, slot_at(56)}, 32'h4);

      // Frame 6 out: read 0x7F answered; stimulus: none
      frame(0, 0, 7'h00, 0, 0, 7'h00, 0, 18'h0);
      k7f = (reg_val(7'h7F) & 16'h0FF0) | (k13 & 16'hF00F);
      chk(slot_at(16) === {1'b0, 7'h7F, 12'h000}, "R4 last command wins (read)", {12'b0, slot_at(16)}, {12'b0, 1'b0, 7'h7F, 12'h000});
      chk(slot_at(36) === {k7f, 4'h0}, "R7 held bits second read", {12'b0, slot_at(36)}, {12'b0, k7f, 4'h0});

      // Frame 7 out: empty frame
      frame(0, 0, 7'h00, 0, 0, 7'h00, 0, 18'h0);
      chk(tag_of() === 16'h8000, "R10 empty frame tag", {16'b0, tag_of()}, 32'h8000);
      repeat (300) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule